// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small on-chip store of 32-bit words and applies single-word atomic operations to it. A requester hands over an opcode, a word address, a source operand and a compare operand through a valid/ready handshake. The unit reads the addressed word, computes the replacement word and writes it back. It then offers the word as it stood before the operation on a response handshake.

Only one operation is in flight at a time. The request side stays closed from the moment a request is taken until its response has been consumed. Any other access therefore lands wholly before or wholly after a given operation. Each operation touches exactly one 32-bit word; there are no vector lanes.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Every accepted request returns on `rsp_data` the addressed word as it was before that request, and the computed word is stored back in the same location.
- R2: Opcode 0 (add) stores old + src modulo 2^32; a carry out is dropped silently.
- R3: Opcode 1 (exchange) stores src unconditionally.
- R4: Opcode 2 (compare-and-swap) stores src only when the old word equals cmp; otherwise the old word is kept.
- R5: Opcodes 3, 4 and 5 store old AND src, old OR src and old XOR src respectively.
- R6: Opcodes 6 and 7 store the unsigned minimum and unsigned maximum of old and src.
- R7: Opcodes 8 and 9 store the minimum and maximum of old and src read as two's complement signed values.
- R8: Opcodes 10 to 15 leave the word unchanged and still return the old word.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle after its response handshake, so a second request is never taken while one is in flight.
- R10: `rsp_valid` rises on the third rising edge after the accepting edge, and while `rsp_ready` is low it stays high with `rsp_data` unchanged.
- R11: Synchronous reset clears all 64 words to zero, raises `req_ready` and lowers `rsp_valid`.
- R12: The 6-bit `req_addr` selects one of 64 independent words; an operation on one word leaves every other word untouched, including the words at addresses 0 and 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 4 | Operation code |
| req_addr | input | 6 | Word address |
| req_src | input | 32 | Source operand |
| req_cmp | input | 32 | Compare operand (compare-and-swap only) |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Word value before the operation |

## Verification
The bench chains operations on the same word, so each stored result is seen as the old value of the next request. A wrong write-back therefore shows up one step later. Add is driven across the 2^32 boundary; an unwrapped or saturating adder would return a wrong value on the following read. Min and max are run with 0x80000000 and 0xFFFFFFFF against small positives; a design that swapped the signed and unsigned comparators gives the opposite winner. Compare-and-swap is tried with both a mismatching and a matching compare value; a design that always wrote, or never wrote, differs on the next read. The remaining checks cover a held-off response, unused opcodes and a reset in the middle of a run. A stalled response that leaked a second request, or a reset that left stale words, is caught at the ports.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam int unsigned ATOM_W     = 32;
    localparam int unsigned ATOM_DEPTH = 64;
    localparam int unsigned ATOM_AW    = $clog2(ATOM_DEPTH);
    localparam int unsigned ATOM_OP_W  = 4;

    typedef enum logic [ATOM_OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_XCHG = 4'd1,
        OP_CAS  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_UMIN = 4'd6,
        OP_UMAX = 4'd7,
        OP_SMIN = 4'd8,
        OP_SMAX = 4'd9
    } atom_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } atom_state_e;

    typedef struct packed {
        logic [ATOM_OP_W-1:0] op;
        logic [ATOM_AW-1:0]   addr;
        logic [ATOM_W-1:0]    src;
        logic [ATOM_W-1:0]    cmp;
    } atom_req_t;

    function automatic logic atom_op_known(input logic [ATOM_OP_W-1:0] op);
        return op <= OP_SMAX;
    endfunction

endpackage

// File: rtl/atom_store.sv
module atom_store #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [ATOM_OP_W-1:0] op,
    input  logic [W-1:0]         old_val,
    input  logic [W-1:0]         src,
    input  logic [W-1:0]         cmp,
    output logic [W-1:0]         new_val
);

    logic          u_lt;
    logic          s_lt;
    logic [W-1:0]  sum;

    assign sum  = old_val + src;
    assign u_lt = old_val < src;
    assign s_lt = $signed(old_val) < $signed(src);

    always_comb begin
        new_val = old_val;
        if (atom_op_known(op)) begin
            unique case (atom_op_e'(op))
                OP_ADD:  new_val = sum;
                OP_XCHG: new_val = src;
                OP_CAS:  new_val = (old_val == cmp) ? src : old_val;
                OP_AND:  new_val = old_val & src;
                OP_OR:   new_val = old_val | src;
                OP_XOR:  new_val = old_val ^ src;
                OP_UMIN: new_val = u_lt ? old_val : src;
                OP_UMAX: new_val = u_lt ? src : old_val;
                OP_SMIN: new_val = s_lt ? old_val : src;
                OP_SMAX: new_val = s_lt ? src : old_val;
                default: new_val = old_val;
            endcase
        end
    end

endmodule

// File: rtl/atom_ctrl.sv
module atom_ctrl
    import atom_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_fire,
    input  atom_req_t      req_in,
    input  logic           rsp_ready,
    output atom_state_e    state,
    output atom_req_t      req_q,
    output logic [W-1:0]   old_q,
    input  logic [W-1:0]   rd_data,
    output logic           wr_en
);

    atom_state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (req_fire)  state_n = ST_READ;
            ST_READ:                 state_n = ST_WRITE;
            ST_WRITE:                state_n = ST_RESP;
            ST_RESP:  if (rsp_ready) state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
            old_q <= '0;
        end else begin
            state <= state_n;
            if (req_fire) begin
                req_q <= req_in;
            end
            if (state == ST_READ) begin
                old_q <= rd_data;
            end
        end
    end

    assign wr_en = (state == ST_WRITE);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ATOM_OP_W-1:0] req_op,
    input  logic [ATOM_AW-1:0]   req_addr,
    input  logic [ATOM_W-1:0]    req_src,
    input  logic [ATOM_W-1:0]    req_cmp,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [ATOM_W-1:0]    rsp_data
);

    atom_state_e         state;
    atom_req_t           req_in;
    atom_req_t           req_q;
    logic [ATOM_W-1:0]   old_q;
    logic [ATOM_W-1:0]   rd_data;
    logic [ATOM_W-1:0]   new_val;
    logic                wr_en;
    logic                req_fire;

    assign req_in    = '{op: req_op, addr: req_addr, src: req_src, cmp: req_cmp};
    assign req_ready = (state == ST_IDLE);
    assign req_fire  = req_valid && req_ready;

    atom_ctrl #(.W(ATOM_W), .DEPTH(ATOM_DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req_in    (req_in),
        .rsp_ready (rsp_ready),
        .state     (state),
        .req_q     (req_q),
        .old_q     (old_q),
        .rd_data   (rd_data),
        .wr_en     (wr_en)
    );

    atom_store #(.W(ATOM_W), .DEPTH(ATOM_DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (req_q.addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (req_q.addr),
        .wr_data (new_val)
    );

    atom_alu #(.W(ATOM_W)) u_alu (
        .op      (req_q.op),
        .old_val (old_q),
        .src     (req_q.src),
        .cmp     (req_q.cmp),
        .new_val (new_val)
    );

    assign rsp_valid = (state == ST_RESP);
    assign rsp_data  = old_q;

endmodule

// File: rtl/atom_rmw_chk.sv
module atom_rmw_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_data
);

    // R9
    accept_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && rsp_valid));

    // R9
    rsp_reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

    // R10
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> ##3 rsp_valid);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

bind atomic_rmw_unit atom_rmw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
);

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_src = '0;
    logic [31:0] req_cmp = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    atomic_rmw_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_src   (req_src),
        .req_cmp   (req_cmp),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data)
    );

    // {op, addr, src, cmp, expected old value}
    localparam int NV = 24;
    localparam logic [105:0] VEC [NV] = '{
        {4'd1, 6'd1,  32'h0000_0010, 32'h0, 32'h0000_0000},
        {4'd0, 6'd1,  32'hFFFF_FFF8, 32'h0, 32'h0000_0010},
        {4'd0, 6'd2,  32'hFFFF_FFFF, 32'h0, 32'h0000_0000},
        {4'd0, 6'd2,  32'h0000_0001, 32'h0, 32'hFFFF_FFFF},
        {4'd1, 6'd3,  32'hF0F0_F0F0, 32'h0, 32'h0000_0000},
        {4'd3, 6'd3,  32'hFF00_FF00, 32'h0, 32'hF0F0_F0F0},
        {4'd4, 6'd3,  32'h0000_000F, 32'h0, 32'hF000_F000},
        {4'd5, 6'd3,  32'hFFFF_FFFF, 32'h0, 32'hF000_F00F},
        {4'd2, 6'd3,  32'h0000_AAAA, 32'h1234_5678, 32'h0FFF_0FF0},
        {4'd2, 6'd3,  32'h0000_AAAA, 32'h0FFF_0FF0, 32'h0FFF_0FF0},
        {4'd1, 6'd4,  32'h8000_0000, 32'h0, 32'h0000_0000},
        {4'd6, 6'd4,  32'h0000_0005, 32'h0, 32'h8000_0000},
        {4'd1, 6'd4,  32'h8000_0000, 32'h0, 32'h0000_0005},
        {4'd8, 6'd4,  32'h0000_0005, 32'h0, 32'h8000_0000},
        {4'd7, 6'd4,  32'h0000_0007, 32'h0, 32'h8000_0000},
        {4'd9, 6'd4,  32'h0000_0007, 32'h0, 32'h8000_0000},
        {4'd9, 6'd4,  32'hFFFF_FFFF, 32'h0, 32'h0000_0007},
        {4'd7, 6'd4,  32'hFFFF_FFFF, 32'h0, 32'h0000_0007},
        {4'd8, 6'd4,  32'h0000_0003, 32'h0, 32'hFFFF_FFFF},
        {4'd6, 6'd4,  32'h0000_0003, 32'h0, 32'hFFFF_FFFF},
        {4'd12, 6'd4, 32'h0000_0099, 32'h0, 32'h0000_0003},
        {4'd1, 6'd63, 32'hDEAD_BEEF, 32'h0, 32'h0000_0000},
        {4'd1, 6'd0,  32'h0000_0001, 32'h0, 32'h0000_0000},
        {4'd1, 6'd63, 32'h0000_0000, 32'h0, 32'hDEAD_BEEF}
    };

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:       return "R2";
            4'd1:       return "R3";
            4'd2:       return "R4";
            4'd3, 4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one request; returns old value, latency and busy/hold violations.
    task automatic do_op(input logic [3:0] op, input logic [5:0] addr,
                         input logic [31:0] src, input logic [31:0] cmp,
                         input int hold, output logic [31:0] old,
                         output int lat, output logic busy_bad,
                         output logic hold_bad, output logic reopen_bad);
        logic [31:0] first;
        busy_bad   = 1'b0;
        hold_bad   = 1'b0;
        reopen_bad = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_src   = src;
        req_cmp   = cmp;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = 4'hF;
        req_src   = 32'h5A5A_5A5A;
        lat = 1;
        while (!rsp_valid && lat < 20) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        if (req_ready) busy_bad = 1'b1;
        first = rsp_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_data !== first || req_ready) hold_bad = 1'b1;
        end
        old = rsp_data;
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        if (rsp_valid || !req_ready) reopen_bad = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] old;
        int          lat;
        logic        b_bad, h_bad, r_bad;
        int          lat_bad;

        repeat (3) @(negedge clk);
        // R11: reset state on the ports
        chk("R11 req_ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Vector table: R1 old value returned, op-specific write-back (R2..R8, R12)
        lat_bad = 0;
        for (int i = 0; i < NV; i++) begin
            logic [105:0] v;
            v = VEC[i];
            do_op(v[105:102], v[101:96], v[95:64], v[63:32], 0, old, lat, b_bad, h_bad, r_bad);
            chk({"R1 ", tag_of(v[105:102])}, old, v[31:0]);
            if (lat != 3 || b_bad || r_bad) lat_bad++;
        end
        // R9 R10: every table request closed the request side and answered in 3 edges
        chk("R9 R10 table handshake", lat_bad, 32'd0);

        // R12: address 0 kept its own value after address 63 traffic
        do_op(4'd1, 6'd0, 32'h0, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        chk("R12 word 0 independent", old, 32'h0000_0001);

        // R10: response held while rsp_ready stays low
        do_op(4'd0, 6'd7, 32'h0000_0042, 32'h0, 5, old, lat, b_bad, h_bad, r_bad);
        chk("R10 latency", lat, 32'd3);
        chk("R10 held response", {31'd0, h_bad}, 32'd0);
        // R9: request side stayed closed through the stall
        chk("R9 busy blocks requests", {31'd0, b_bad}, 32'd0);
        chk("R9 reopen after response", {31'd0, r_bad}, 32'd0);

        // R2: back-to-back on the same word sees the earlier write
        do_op(4'd0, 6'd7, 32'h0000_0001, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        chk("R2 back-to-back add", old, 32'h0000_0042);

        // R4: matching swap stored src (seen by next read)
        do_op(4'd1, 6'd3, 32'h0, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        chk("R4 cas stored src", old, 32'h0000_AAAA);

        // R11: reset in mid-run clears memory
        do_op(4'd1, 6'd5, 32'h0000_0055, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_op(4'd1, 6'd5, 32'h0, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        chk("R11 memory cleared addr5", old, 32'h0);
        do_op(4'd1, 6'd7, 32'h0, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        chk("R11 memory cleared addr7", old, 32'h0);

        // R8: unused code 15 leaves word alone
        do_op(4'd1, 6'd9, 32'h1357_9BDF, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        do_op(4'd15, 6'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, old, lat, b_bad, h_bad, r_bad);
        chk("R8 unused op returns old", old, 32'h1357_9BDF);
        do_op(4'd1, 6'd9, 32'h0, 32'h0, 0, old, lat, b_bad, h_bad, r_bad);
        chk("R8 unused op kept word", old, 32'h1357_9BDF);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule